// File: doc/BRIEF.md
# Sixteen-Pin Register-Controlled I/O Port

This block is a sixteen-pin general-purpose port that software configures and drives through a small synchronous register bus. Each pin has a two-bit mode that makes it an input, a software-driven output, an output owned by an on-chip peripheral, or an analog pin. Software writes the output value directly, or sets and clears single bits in one write without a read-modify-write. The input value is sampled from the pins on every clock through a two-stage synchronizer.

The bus uses a word index, four byte-lane strobes, a write strobe and a read strobe. A read returns its data one clock after the strobe, and the data holds until the next read. Per pin, the block drives a pad value, a drive enable, pull requests, a two-bit slew grade and a four-bit peripheral select. It also takes a per-pin value from the peripherals for pins in peripheral mode.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads 0. Every pin is an input with drive enable low and no pull request, and every peripheral select is 0.
- R2: The mode field of pin n sits at bits 2n+1:2n of word 0 (byte offset 0x00). Code 00 is input, 01 is software output, 10 is peripheral and 11 is analog. A pin in code 01 drives its output-data bit with drive enable high.
- R3: Output data sits at word 5 (offset 0x14), bit n for pin n. A read returns the last value written, and a write changes only the byte lanes whose strobe is 1.
- R4: The word at index 6 (offset 0x18) is write-only and reads 0. Write bits 15:0 set the matching output bits, and bits 31:16 clear them. A 0 bit leaves its output bit alone. When both the set bit and the clear bit of a pin are 1, the bit ends at 1.
- R5: A halfword write to offset 0x1A (word 6, lane strobes 1100) clears bits only. The lower lanes are ignored, whatever their data.
- R6: Word 1 (offset 0x04) bit n set to 1 makes pin n open-drain. An open-drain pin that drives 1 has its drive enable low, and one that drives 0 has it high. A 0 in that bit gives push-pull drive.
- R7: A pin in analog mode has drive enable low and no pull request, and it reads 0 in the input-data word.
- R8: Input data is word 4 (offset 0x10). It is read-only and ignores writes. A pin change is visible in a read issued 3 or more clocks later, and not in a read issued in the same clock.
- R9: The pull field of pin n sits at bits 2n+1:2n of word 3 (offset 0x0C). Code 01 requests pull-up, 10 requests pull-down, and 00 and 11 request no pull.
- R10: In peripheral mode, the pad value of pin n follows the peripheral input bit n. The 4-bit select of pin n is bits 4n+3:4n of the select output. Pins 0-7 come from word 8 (offset 0x20) and pins 8-15 from word 9 (offset 0x24), each in nibble order.
- R11: Word 7 (offset 0x1C) and word indices 10-15 read 0 and ignore writes. Writes to them leave the other registers unchanged.
- R12: The slew field of pin n sits at bits 2n+1:2n of word 2 (offset 0x08). It appears unchanged on the slew output and reads back as written.
- R13: Read data changes only on the clock edge that samples the read strobe, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busWordAddr | input | 4 | Word index (byte offset / 4) |
| busWdata | input | 32 | Write data |
| busBe | input | 4 | Byte-lane strobes |
| busWr | input | 1 | Write strobe, one clock per write |
| busRd | input | 1 | Read strobe, one clock per read |
| busRdata | output | 32 | Read data, valid the clock after the read strobe |
| pinIn | input | 16 | Levels sampled from the pads |
| afOut | input | 16 | Per-pin values from the on-chip peripherals |
| pinOut | output | 16 | Pad drive value |
| pinOe | output | 16 | Pad drive enable |
| pullUp | output | 16 | Pull-up requests |
| pullDown | output | 16 | Pull-down requests |
| padSpeed | output | 32 | Two-bit slew grade per pin |
| afSel | output | 64 | Four-bit peripheral select per pin |

## Verification
The assertions assume that reads and writes never coincide, because each strobe pulses for one clock with no overlap. They also assume that the byte-lane strobes are meaningful only alongside a write. The bench's bus tasks raise exactly one strobe for one clock, away from the clock edge, and hold the address and data steady around it. The pad inputs and the peripheral inputs may change at any time. Only the synchronizer sees the pad inputs, so the input-data property relies on the mode register alone.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [3:0] {
    SEL_MODE,
    SEL_TYPE,
    SEL_SPEED,
    SEL_PULL,
    SEL_IDR,
    SEL_ODR,
    SEL_AFL,
    SEL_AFH,
    SEL_ZERO
  } rdSel_e;

  typedef struct packed {
    logic        wrMode;
    logic        wrType;
    logic        wrSpeed;
    logic        wrPull;
    logic        wrOdr;
    logic        wrBsr;
    logic        wrAfl;
    logic        wrAfh;
    logic        rdEn;
    rdSel_e      rdSel;
    logic [31:0] laneMask;
  } busStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int WADDR_W = 4,
  parameter int LANES   = 4
) (
  input  logic [WADDR_W-1:0] busWordAddr,
  input  logic [LANES-1:0]   busBe,
  input  logic               busWr,
  input  logic               busRd,
  output busStrobe_t         strb
);

  logic [8*LANES-1:0] laneMask;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneMask[8*g +: 8] = {8{busBe[g]}};
  end

  always_comb begin
    strb          = '0;
    strb.laneMask = laneMask;
    strb.rdEn     = busRd;
    strb.rdSel    = SEL_ZERO;
    case (busWordAddr)
      4'd0: begin strb.wrMode  = busWr; strb.rdSel = SEL_MODE;  end
      4'd1: begin strb.wrType  = busWr; strb.rdSel = SEL_TYPE;  end
      4'd2: begin strb.wrSpeed = busWr; strb.rdSel = SEL_SPEED; end
      4'd3: begin strb.wrPull  = busWr; strb.rdSel = SEL_PULL;  end
      4'd4: begin                       strb.rdSel = SEL_IDR;   end
      4'd5: begin strb.wrOdr   = busWr; strb.rdSel = SEL_ODR;   end
      4'd6: begin strb.wrBsr   = busWr; strb.rdSel = SEL_ZERO;  end
      4'd8: begin strb.wrAfl   = busWr; strb.rdSel = SEL_AFL;   end
      4'd9: begin strb.wrAfh   = busWr; strb.rdSel = SEL_AFH;   end
      default: strb.rdSel = SEL_ZERO;
    endcase
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int AFW   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  busStrobe_t           strb,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NPINS-1:0]     pinIn,
  input  logic [NPINS-1:0]     afOut,
  output logic [NPINS-1:0]     pinOut,
  output logic [NPINS-1:0]     pinOe,
  output logic [NPINS-1:0]     pullUp,
  output logic [NPINS-1:0]     pullDown,
  output logic [2*NPINS-1:0]   padSpeed,
  output logic [NPINS*AFW-1:0] afSel
);

  localparam int MW    = 2 * NPINS;
  localparam int AFALL = NPINS * AFW;

  logic [MW-1:0]    modeQ, speedQ, pullQ;
  logic [NPINS-1:0] typeQ, odrQ, syncA, syncB, idrQ;
  logic [31:0]      afLoQ, afHiQ, rdataQ;
  logic [63:0]      afAll;
  logic [NPINS-1:0] setBits, clrBits, analogMask;
  logic [NPINS-1:0] wMaskLo;
  logic [MW-1:0]    wMaskMode;

  assign wMaskLo   = strb.laneMask[NPINS-1:0];
  assign wMaskMode = strb.laneMask[MW-1:0];
  assign setBits   = busWdata[NPINS-1:0] & strb.laneMask[NPINS-1:0];
  assign clrBits   = busWdata[16 +: NPINS] & strb.laneMask[16 +: NPINS];

  // configuration registers with byte-lane merge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeQ  <= '0;
      typeQ  <= '0;
      speedQ <= '0;
      pullQ  <= '0;
      afLoQ  <= '0;
      afHiQ  <= '0;
    end else begin
      if (strb.wrMode)  modeQ  <= (modeQ  & ~wMaskMode) | (busWdata[MW-1:0] & wMaskMode);
      if (strb.wrType)  typeQ  <= (typeQ  & ~wMaskLo)   | (busWdata[NPINS-1:0] & wMaskLo);
      if (strb.wrSpeed) speedQ <= (speedQ & ~wMaskMode) | (busWdata[MW-1:0] & wMaskMode);
      if (strb.wrPull)  pullQ  <= (pullQ  & ~wMaskMode) | (busWdata[MW-1:0] & wMaskMode);
      if (strb.wrAfl)   afLoQ  <= (afLoQ & ~strb.laneMask) | (busWdata & strb.laneMask);
      if (strb.wrAfh)   afHiQ  <= (afHiQ & ~strb.laneMask) | (busWdata & strb.laneMask);
    end
  end

  // output data: plain write or atomic set/clear, set dominating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odrQ <= '0;
    end else if (strb.wrOdr) begin
      odrQ <= (odrQ & ~wMaskLo) | (busWdata[NPINS-1:0] & wMaskLo);
    end else if (strb.wrBsr) begin
      odrQ <= (odrQ & ~clrBits) | setBits;
    end
  end

  // two-stage synchronizer, then capture gated by analog mode
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncA <= '0;
      syncB <= '0;
      idrQ  <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      idrQ  <= syncB & ~analogMask;
    end
  end

  // per-pin drive logic
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [1:0] pinMode, pinPull;
    logic       isOut, isAf, isAna, drvVal;
    assign pinMode       = modeQ[2*p +: 2];
    assign pinPull       = pullQ[2*p +: 2];
    assign isOut         = (pinMode == 2'b01);
    assign isAf          = (pinMode == 2'b10);
    assign isAna         = (pinMode == 2'b11);
    assign drvVal        = isOut ? odrQ[p] : (isAf ? afOut[p] : 1'b0);
    assign analogMask[p] = isAna;
    assign pinOut[p]     = drvVal;
    assign pinOe[p]      = (isOut | isAf) & (~typeQ[p] | ~drvVal);
    assign pullUp[p]     = ~isAna & (pinPull == 2'b01);
    assign pullDown[p]   = ~isAna & (pinPull == 2'b10);
  end

  assign afAll    = {afHiQ, afLoQ};
  assign afSel    = afAll[AFALL-1:0];
  assign padSpeed = speedQ;

  // registered read port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdataQ <= '0;
    end else if (strb.rdEn) begin
      case (strb.rdSel)
        SEL_MODE:  rdataQ <= 32'(modeQ);
        SEL_TYPE:  rdataQ <= 32'(typeQ);
        SEL_SPEED: rdataQ <= 32'(speedQ);
        SEL_PULL:  rdataQ <= 32'(pullQ);
        SEL_IDR:   rdataQ <= 32'(idrQ);
        SEL_ODR:   rdataQ <= 32'(odrQ);
        SEL_AFL:   rdataQ <= afLoQ;
        SEL_AFH:   rdataQ <= afHiQ;
        default:   rdataQ <= '0;
      endcase
    end
  end

  assign busRdata = rdataQ;

  // R4: every set bit of an atomic write lands as 1
  assert_bsr_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrBsr |=> ((odrQ & $past(setBits)) == $past(setBits)));

  // R5: clear-only bits of an atomic write land as 0
  assert_bsr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrBsr |=> ((odrQ & $past(clrBits & ~setBits)) == '0));

  // R4: the atomic word reads back as zero
  assert_bsr_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rdEn && strb.rdSel == SEL_ZERO) |=> (busRdata == '0));

  // R6: an open-drain pin never actively drives a 1
  assert_od_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pinOe & typeQ & pinOut) == '0));

  // R7: analog pins read 0 once their mode has settled
  assert_analog_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(modeQ) |-> ((idrQ & analogMask) == '0));

  // R9: never both pulls on the same pin
  assert_pull_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pullUp & pullDown) == '0));

  // R13: read data holds when no read is issued
  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.rdEn |=> $stable(busRdata));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS   = 16,
  parameter int AFW     = 4,
  parameter int WADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WADDR_W-1:0]   busWordAddr,
  input  logic [31:0]          busWdata,
  input  logic [3:0]           busBe,
  input  logic                 busWr,
  input  logic                 busRd,
  output logic [31:0]          busRdata,
  input  logic [NPINS-1:0]     pinIn,
  input  logic [NPINS-1:0]     afOut,
  output logic [NPINS-1:0]     pinOut,
  output logic [NPINS-1:0]     pinOe,
  output logic [NPINS-1:0]     pullUp,
  output logic [NPINS-1:0]     pullDown,
  output logic [2*NPINS-1:0]   padSpeed,
  output logic [NPINS*AFW-1:0] afSel
);

  busStrobe_t strb;

  gpio_port_ctrl #(.WADDR_W(WADDR_W), .LANES(4)) u_ctrl (
    .busWordAddr(busWordAddr),
    .busBe      (busBe),
    .busWr      (busWr),
    .busRd      (busRd),
    .strb       (strb)
  );

  gpio_port_dp #(.NPINS(NPINS), .AFW(AFW)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .pinIn   (pinIn),
    .afOut   (afOut),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .pullUp  (pullUp),
    .pullDown(pullDown),
    .padSpeed(padSpeed),
    .afSel   (afSel)
  );

endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  busWordAddr = '0;
  logic [31:0] busWdata = '0;
  logic [3:0]  busBe = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busRdata;
  logic [15:0] pinIn = '0;
  logic [15:0] afOut = '0;
  logic [15:0] pinOut, pinOe, pullUp, pullDown;
  logic [31:0] padSpeed;
  logic [63:0] afSel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  gpio_port u_gpio_port (
    .clk(clk), .rst_n(rst_n), .busWordAddr(busWordAddr), .busWdata(busWdata),
    .busBe(busBe), .busWr(busWr), .busRd(busRd), .busRdata(busRdata),
    .pinIn(pinIn), .afOut(afOut), .pinOut(pinOut), .pinOe(pinOe),
    .pullUp(pullUp), .pullDown(pullDown), .padSpeed(padSpeed), .afSel(afSel)
  );

  // 8 time-unit period: 125 MHz with a 1 ns unit
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] wa, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    busWordAddr = wa; busWdata = d; busBe = be; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busBe = '0;
  endtask

  task automatic busRead(input logic [3:0] wa, output logic [31:0] d);
    @(negedge clk);
    busWordAddr = wa; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    for (int w = 0; w < 16; w++) begin
      busRead(w[3:0], d);
      check("R1 reset readback", 64'(d), 64'h0);
    end
    check("R1 reset oe", 64'(pinOe), 64'h0);
    check("R1 reset pulls", 64'({pullUp, pullDown}), 64'h0);
    check("R1 reset afsel", afSel, 64'h0);
  endtask

  task automatic testOutput();
    logic [31:0] d;
    busWrite(4'd0, 32'h5555_5555, 4'hF);
    busWrite(4'd5, 32'h0000_A5C3, 4'hF);
    check("R2 output drive value", 64'(pinOut), 64'hA5C3);
    check("R2 output enable", 64'(pinOe), 64'hFFFF);
    busRead(4'd5, d);
    check("R3 odr readback", 64'(d), 64'hA5C3);
    busWrite(4'd5, 32'hFFFF_1234, 4'b0001);
    busRead(4'd5, d);
    check("R3 odr byte lane", 64'(d), 64'hA534);
  endtask

  task automatic testSetClear();
    logic [31:0] d;
    busWrite(4'd5, 32'h0000_00F0, 4'hF);
    busWrite(4'd6, 32'h0011_0003, 4'hF);
    check("R4 set wins over clear", 64'(pinOut), 64'h00E3);
    busRead(4'd6, d);
    check("R4 atomic word reads zero", 64'(d), 64'h0);
    busWrite(4'd6, 32'h0080_FFFF, 4'b1100);
    busRead(4'd5, d);
    check("R5 upper halfword clears only", 64'(d), 64'h0063);
  endtask

  task automatic testOpenDrain();
    busWrite(4'd1, 32'h0000_000F, 4'hF);
    check("R6 open-drain oe", 64'(pinOe), 64'hFFFC);
    check("R6 open-drain value", 64'(pinOut), 64'h0063);
    busWrite(4'd1, 32'h0000_0000, 4'hF);
    check("R6 push-pull oe", 64'(pinOe), 64'hFFFF);
  endtask

  task automatic testAltFunc();
    busWrite(4'd0, 32'h5555_55AA, 4'hF);
    afOut = 16'hFFFA;
    @(negedge clk);
    check("R10 af pad value", 64'(pinOut), 64'h006A);
    check("R10 af drive enable", 64'(pinOe), 64'hFFFF);
    busWrite(4'd8, 32'h7654_3210, 4'hF);
    busWrite(4'd9, 32'hFEDC_BA98, 4'hF);
    check("R10 af select layout", afSel, 64'hFEDC_BA98_7654_3210);
    afOut = '0;
  endtask

  task automatic testPullSpeed();
    logic [31:0] d;
    busWrite(4'd0, 32'h0, 4'hF);
    busWrite(4'd3, 32'h0000_00E4, 4'hF);
    check("R9 pull-up", 64'(pullUp), 64'h0002);
    check("R9 pull-down", 64'(pullDown), 64'h0004);
    busWrite(4'd2, 32'h8000_001B, 4'hF);
    check("R12 slew output", 64'(padSpeed), 64'h8000_001B);
    busRead(4'd2, d);
    check("R12 slew readback", 64'(d), 64'h8000_001B);
  endtask

  task automatic testAnalog();
    logic [31:0] d;
    busWrite(4'd0, 32'h0000_00FF, 4'hF);
    check("R7 analog pulls off", 64'({pullUp, pullDown}), 64'h0);
    check("R7 analog no drive", 64'(pinOe & 16'h000F), 64'h0);
    pinIn = 16'hFFFF;
    waitCycles(4);
    busRead(4'd4, d);
    check("R7 analog reads zero", 64'(d), 64'hFFF0);
    busWrite(4'd0, 32'h0, 4'hF);
    busWrite(4'd3, 32'h0, 4'hF);
    pinIn = '0;
    waitCycles(4);
  endtask

  task automatic testInputSync();
    logic [31:0] d;
    @(negedge clk);
    pinIn = 16'h1234;
    busWordAddr = 4'd4; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    check("R8 same-clock read sees old", 64'(busRdata), 64'h0);
    check("R13 read data holds", 64'(busRdata), 64'h0);
    waitCycles(2);
    busRead(4'd4, d);
    check("R8 input after sync", 64'(d), 64'h1234);
    busWrite(4'd4, 32'h0000_FFFF, 4'hF);
    busRead(4'd4, d);
    check("R8 input is read-only", 64'(d), 64'h1234);
  endtask

  task automatic testUnused();
    logic [31:0] d;
    busWrite(4'd7, 32'hFFFF_FFFF, 4'hF);
    busWrite(4'd10, 32'hFFFF_FFFF, 4'hF);
    busWrite(4'd15, 32'hFFFF_FFFF, 4'hF);
    busRead(4'd7, d);
    check("R11 lock word reads zero", 64'(d), 64'h0);
    busRead(4'd10, d);
    check("R11 unused word reads zero", 64'(d), 64'h0);
    busRead(4'd5, d);
    check("R11 odr untouched", 64'(d), 64'h0063);
    busRead(4'd0, d);
    check("R11 mode untouched", 64'(d), 64'h0);
  endtask

  initial begin
    waitCycles(3);
    @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testOutput();
    testSetClear();
    testOpenDrain();
    testAltFunc();
    testPullSpeed();
    testAnalog();
    testInputSync();
    testUnused();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitCycles(20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule